// File: doc/BRIEF.md
# UART Interrupt Identification and Line Status Merger

This block sits between the receive/transmit datapath of a 16550-style serial port and its register read path. It gathers three interrupt sources (a receive line error, received data reaching its reporting condition, and an empty transmit holding register) and resolves them by fixed priority into one identification byte. It also assembles the line-status byte and drives the single interrupt request line.

Two sources have read side effects. The overrun flag is sticky and is cleared by a line-status read. The transmit-empty source is cleared by reading the identification byte while that byte shows the transmit-empty code. It comes back only when the holding register empties again. When FIFO mode is on, the identification byte carries a two-bit marker in its upper bits.

Top module: `uart_intid_lsr`

## Requirements
- R1: After synchronous reset, with the transmit holding register not empty and all other inputs low, the identification byte reads 0x01, the line-status byte reads 0x00 and the interrupt line is low.
- R2: The low nibble of the identification byte gives the highest enabled pending source: 0x6 for a line error (overrun), then 0x4 for received data, then 0x2 for transmit holding empty, and 0x1 when none is pending.
- R3: Enable bit 0 gates the received-data source, bit 1 gates the transmit-empty source and bit 2 gates the line-error source. A disabled source never appears in the identification byte.
- R4: Identification bits 7:6 read 11 while FIFO mode is enabled and 00 otherwise. Bits 5:4 always read 0, so the idle value is 0xC1 in FIFO mode.
- R5: In the line-status byte, bit 6 is set when both the holding register and the shift register are empty, bit 5 is set when the holding register is empty, bit 1 is the overrun flag and bit 0 is data ready. All other bits read 0. For example, an idle transmitter with data gives 0x61, and with an overrun it gives 0x63.
- R6: The overrun flag is set in the cycle after an overrun event and holds until a line-status read. It is clear in the cycle after that read, unless a new overrun event arrives in the same cycle as the read.
- R7: A read of the identification byte while it shows 0x2 clears the transmit-empty source from the next cycle. A read while another code is shown leaves that source pending.
- R8: The transmit-empty source is armed in the cycle after the holding-empty input rises. It is masked immediately and disarmed when that input falls.
- R9: The interrupt line is high exactly when any enabled source is pending, that is, when identification bit 0 is 0.
- R10: A line-status read does not change a pending transmit-empty or received-data indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 3 | Source enables: bit0 rx data, bit1 tx empty, bit2 line error |
| fifo_en_i | input | 1 | FIFO mode enabled |
| rx_avail_i | input | 1 | Received-data interrupt condition (data present or trigger level reached) |
| rx_nonempty_i | input | 1 | At least one received byte is held |
| thr_empty_i | input | 1 | Transmit holding register empty |
| tsr_empty_i | input | 1 | Transmit shift register idle |
| ovr_evt_i | input | 1 | One-cycle overrun event |
| rd_iir_i | input | 1 | Identification byte read strobe |
| rd_lsr_i | input | 1 | Line-status read strobe |
| iir_o | output | 8 | Identification byte |
| lsr_o | output | 8 | Line-status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the read strobes and the overrun event are single-cycle pulses sampled at the rising edge. They also assume that the received-data condition is a level that the surrounding FIFO holds steady between edges. The bench changes every input only just after a rising edge, and raises each strobe for exactly one cycle, so that each state change is attributed to one edge. The sweep covers every combination of enables, FIFO mode, received data, armed transmit-empty and sticky overrun. It sets up the internal state only through the normal transmit-empty edges, overrun pulses and status reads.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;

    localparam int REG_W  = 8;
    localparam int SRC_N  = 3;
    localparam int CODE_W = 4;

    // enable bit positions (decoded by the bus register file)
    localparam int EN_RXD  = 0;
    localparam int EN_THRE = 1;
    localparam int EN_LINE = 2;

    // line-status bit positions
    localparam int LS_DR   = 0;
    localparam int LS_OVR  = 1;
    localparam int LS_THRE = 5;
    localparam int LS_TEMT = 6;

    typedef enum logic [CODE_W-1:0] {
        ID_NONE = 4'h1,
        ID_THRE = 4'h2,
        ID_RXD  = 4'h4,
        ID_LINE = 4'h6
    } iid_e;

    typedef struct packed {
        logic line;
        logic rxd;
        logic thre;
    } src_t;

    function automatic iid_e pick_code(input src_t s);
        if (s.line)      return ID_LINE;
        else if (s.rxd)  return ID_RXD;
        else if (s.thre) return ID_THRE;
        else             return ID_NONE;
    endfunction

    function automatic logic [REG_W-1:0] pack_iir(input iid_e c, input logic fifo);
        logic [REG_W-1:0] v;
        v = '0;
        v[CODE_W-1:0] = c;
        v[REG_W-1:REG_W-2] = {2{fifo}};
        return v;
    endfunction

endpackage

// File: rtl/uirq_ovr_track.sv
`timescale 1ns/1ps
module uirq_ovr_track (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic rd_clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (evt_i)
            flag_q <= 1'b1;
        else if (rd_clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/uirq_thre_track.sv
`timescale 1ns/1ps
module uirq_thre_track (
    input  logic clk,
    input  logic rst,
    input  logic empty_i,
    input  logic rd_clr_i,
    output logic pend_o
);
    logic empty_q;
    logic pend_q;
    logic rise;

    assign rise = empty_i & ~empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            empty_q <= empty_i;
            if (rise)
                pend_q <= 1'b1;
            else if (!empty_i || rd_clr_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q & empty_i;
endmodule

// File: rtl/uirq_resolve.sv
`timescale 1ns/1ps
module uirq_resolve
    import uirq_pkg::*;
(
    input  src_t                raw_i,
    input  logic [SRC_N-1:0]    en_i,
    input  logic                fifo_i,
    output iid_e                code_o,
    output logic [REG_W-1:0]    iir_o,
    output logic                irq_o
);
    src_t gated;

    always_comb begin
        gated.line = raw_i.line & en_i[EN_LINE];
        gated.rxd  = raw_i.rxd  & en_i[EN_RXD];
        gated.thre = raw_i.thre & en_i[EN_THRE];
        code_o     = pick_code(gated);
        iir_o      = pack_iir(code_o, fifo_i);
        irq_o      = |gated;
    end
endmodule

// File: rtl/uart_intid_lsr.sv
`timescale 1ns/1ps
module uart_intid_lsr
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ier_i,
    input  logic             fifo_en_i,
    input  logic             rx_avail_i,
    input  logic             rx_nonempty_i,
    input  logic             thr_empty_i,
    input  logic             tsr_empty_i,
    input  logic             ovr_evt_i,
    input  logic             rd_iir_i,
    input  logic             rd_lsr_i,
    output logic [7:0]       iir_o,
    output logic [7:0]       lsr_o,
    output logic             irq_o
);
    logic ovr_flag;
    logic thre_pend;
    logic thre_clr;
    iid_e cur_code;
    src_t raw;

    uirq_ovr_track u_ovr (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (ovr_evt_i),
        .rd_clr_i (rd_lsr_i),
        .flag_o   (ovr_flag)
    );

    // clear only when the read actually observed the transmit-empty code
    assign thre_clr = rd_iir_i & (cur_code == ID_THRE);

    uirq_thre_track u_thre (
        .clk      (clk),
        .rst      (rst),
        .empty_i  (thr_empty_i),
        .rd_clr_i (thre_clr),
        .pend_o   (thre_pend)
    );

    always_comb begin
        raw.line = ovr_flag;
        raw.rxd  = rx_avail_i;
        raw.thre = thre_pend;
    end

    uirq_resolve u_res (
        .raw_i  (raw),
        .en_i   (ier_i),
        .fifo_i (fifo_en_i),
        .code_o (cur_code),
        .iir_o  (iir_o),
        .irq_o  (irq_o)
    );

    always_comb begin
        lsr_o          = '0;
        lsr_o[LS_DR]   = rx_nonempty_i;
        lsr_o[LS_OVR]  = ovr_flag;
        lsr_o[LS_THRE] = thr_empty_i;
        lsr_o[LS_TEMT] = thr_empty_i & tsr_empty_i;
    end
endmodule

// File: rtl/uart_intid_lsr_chk.sv
`timescale 1ns/1ps
module uart_intid_lsr_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] ier_i,
    input logic       fifo_en_i,
    input logic       rx_avail_i,
    input logic       thr_empty_i,
    input logic       ovr_evt_i,
    input logic       rd_iir_i,
    input logic       rd_lsr_i,
    input logic [7:0] iir_o,
    input logic [7:0] lsr_o,
    input logic       irq_o
);
    p_line_first_r2: assert property (@(posedge clk) disable iff (rst)
        (lsr_o[1] && ier_i[2]) |-> (iir_o[3:0] == 4'h6));

    p_rxd_second_r2: assert property (@(posedge clk) disable iff (rst)
        (!(lsr_o[1] && ier_i[2]) && rx_avail_i && ier_i[0]) |-> (iir_o[3:0] == 4'h4));

    p_all_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (ier_i == 3'b000) |-> (iir_o[3:0] == 4'h1));

    p_fifo_marker_r4: assert property (@(posedge clk) disable iff (rst)
        iir_o[7:6] == {2{fifo_en_i}});

    p_ovr_set_r6: assert property (@(posedge clk) disable iff (rst)
        ovr_evt_i |=> lsr_o[1]);

    p_ovr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (lsr_o[1] && !rd_lsr_i) |=> lsr_o[1]);

    p_ovr_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr_i && !ovr_evt_i) |=> !lsr_o[1]);

    p_thre_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_iir_i && iir_o[3:0] == 4'h2) |=> (iir_o[3:0] != 4'h2));

    p_thre_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !thr_empty_i |-> (iir_o[3:0] != 4'h2));

    p_irq_line_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o == !iir_o[0]);
endmodule

bind uart_intid_lsr uart_intid_lsr_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .ier_i       (ier_i),
    .fifo_en_i   (fifo_en_i),
    .rx_avail_i  (rx_avail_i),
    .thr_empty_i (thr_empty_i),
    .ovr_evt_i   (ovr_evt_i),
    .rd_iir_i    (rd_iir_i),
    .rd_lsr_i    (rd_lsr_i),
    .iir_o       (iir_o),
    .lsr_o       (lsr_o),
    .irq_o       (irq_o)
);

// File: tb/uart_intid_lsr_tb.sv
`timescale 1ns/1ps
module uart_intid_lsr_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ier = '0;
    logic       fifo_en = 1'b0;
    logic       rx_avail = 1'b0;
    logic       rx_nonempty = 1'b0;
    logic       thr_empty = 1'b0;
    logic       tsr_empty = 1'b0;
    logic       ovr_evt = 1'b0;
    logic       rd_iir = 1'b0;
    logic       rd_lsr = 1'b0;
    logic [7:0] iir;
    logic [7:0] lsr;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_intid_lsr dut_i (
        .clk           (clk),
        .rst           (rst),
        .ier_i         (ier),
        .fifo_en_i     (fifo_en),
        .rx_avail_i    (rx_avail),
        .rx_nonempty_i (rx_nonempty),
        .thr_empty_i   (thr_empty),
        .tsr_empty_i   (tsr_empty),
        .ovr_evt_i     (ovr_evt),
        .rd_iir_i      (rd_iir),
        .rd_lsr_i      (rd_lsr),
        .iir_o         (iir),
        .lsr_o         (lsr),
        .irq_o         (irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_iir(input logic [2:0] en, input logic f,
                                           input logic rx, input logic t, input logic o);
        logic [3:0] c;
        if (o && en[2])       c = 4'h6;
        else if (rx && en[0]) c = 4'h4;
        else if (t && en[1])  c = 4'h2;
        else                  c = 4'h1;
        return {f, f, 2'b00, c};
    endfunction

    // bring tx-empty and overrun state into a known condition via ports only
    task automatic prep(input logic t, input logic o);
        ier = '0; rx_avail = 1'b0; rx_nonempty = 1'b0;
        thr_empty = 1'b0; tsr_empty = 1'b0;
        step();
        thr_empty = t; tsr_empty = t;
        step();
        if (o) ovr_evt = 1'b1; else rd_lsr = 1'b1;
        step();
        ovr_evt = 1'b0; rd_lsr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        chk("R1 iir after reset", iir, 8'h01);
        chk("R1 lsr after reset", lsr, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);

        // sweep: enables x fifo x rx x armed tx-empty x overrun
        for (int t = 0; t < 2; t++) begin
            for (int o = 0; o < 2; o++) begin
                step();
                prep(t[0], o[0]);
                for (int e = 0; e < 8; e++) begin
                    for (int f = 0; f < 2; f++) begin
                        for (int r = 0; r < 2; r++) begin
                            ier = e[2:0]; fifo_en = f[0];
                            rx_avail = r[0]; rx_nonempty = r[0];
                            @(negedge clk);
                            // R2 R3 R4 priority, masking and marker
                            chk("R2/R3/R4 iir sweep", iir,
                                exp_iir(e[2:0], f[0], r[0], t[0], o[0]));
                            // R9 interrupt line
                            chk("R9 irq sweep", {7'b0, irq},
                                {7'b0, exp_iir(e[2:0], f[0], r[0], t[0], o[0]) != {f[0], f[0], 6'h01}});
                            // R5 line-status layout
                            chk("R5 lsr sweep", lsr,
                                {1'b0, t[0], t[0], 3'b000, o[0], r[0]});
                        end
                    end
                end
                fifo_en = 1'b0; rx_avail = 1'b0; rx_nonempty = 1'b0;
            end
        end

        // R7: read while showing 0x2 clears the source
        step(); prep(1'b1, 1'b0);
        ier = 3'b010;
        @(negedge clk);
        chk("R7 shows tx-empty", iir, 8'h02);
        step(); rd_iir = 1'b1; step(); rd_iir = 1'b0;
        @(negedge clk);
        chk("R7 cleared by read", iir, 8'h01);
        chk("R7 irq low after read", {7'b0, irq}, 8'h00);

        // R7: read while showing rx code keeps tx-empty pending
        step(); prep(1'b1, 1'b0);
        ier = 3'b011; rx_avail = 1'b1;
        @(negedge clk);
        chk("R7 rx shown first", iir, 8'h04);
        step(); rd_iir = 1'b1; step(); rd_iir = 1'b0; rx_avail = 1'b0;
        @(negedge clk);
        chk("R7 tx-empty kept", iir, 8'h02);

        // R8: masked at once on fall, rearmed one cycle after rise
        thr_empty = 1'b0;
        @(negedge clk);
        chk("R8 masked on fall", iir, 8'h01);
        step(); thr_empty = 1'b1;
        @(negedge clk);
        chk("R8 not yet rearmed", iir, 8'h01);
        step();
        @(negedge clk);
        chk("R8 rearmed after rise", iir, 8'h02);

        // R10: status read leaves tx-empty and rx indication alone
        step(); rd_lsr = 1'b1; step(); rd_lsr = 1'b0;
        @(negedge clk);
        chk("R10 tx-empty after lsr read", iir, 8'h02);
        ier = 3'b011; rx_avail = 1'b1;
        step(); rd_lsr = 1'b1; step(); rd_lsr = 1'b0;
        @(negedge clk);
        chk("R10 rx after lsr read", iir, 8'h04);
        rx_avail = 1'b0;

        // R6: sticky hold, simultaneous event and read, then clear
        step(); prep(1'b1, 1'b1);
        ier = 3'b111; rx_avail = 1'b1; rx_nonempty = 1'b1;
        repeat (3) step();
        @(negedge clk);
        chk("R6 overrun held", lsr, 8'h63);
        chk("R6 line code over rx", iir, 8'h06);
        step(); ovr_evt = 1'b1; rd_lsr = 1'b1; step(); ovr_evt = 1'b0; rd_lsr = 1'b0;
        @(negedge clk);
        chk("R6 event wins over read", lsr, 8'h63);
        step(); rd_lsr = 1'b1; step(); rd_lsr = 1'b0;
        @(negedge clk);
        chk("R6 cleared by read", lsr, 8'h61);
        chk("R6 falls back to rx code", iir, 8'h04);
        fifo_en = 1'b1;
        @(negedge clk);
        chk("R4 fifo rx code", iir, 8'hC4);
        rx_avail = 1'b0; ier = 3'b001;
        @(negedge clk);
        chk("R4 fifo idle", iir, 8'hC1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule